// File: doc/BRIEF.md
# PC Card Flash Array Control Decoder

This block is the control logic of a removable linear flash card. On one side it takes the host's card bus: a byte address, two active-low byte enables, output and write strobes, the attribute-plane select, an active-high card reset and a hardware write-protect switch. On the other side it drives an array of 8-bit flash devices arranged as pairs. In each pair one device holds the even (low) byte of a word and the other holds the odd (high) byte. The block produces one chip select per pair and separate low-device and high-device read and write strobes. It also steers bytes between the host's two data lanes and the devices, drives a select for the attribute memory, and merges the ready lines of all devices into one card-ready output.

A 16-bit host enables both lanes at once. An 8-bit host enables only the low lane and uses address bit 0 to reach the odd byte, which the block routes through the low lane. The number of populated pairs is a parameter. Each pair spans 8 MB of card space, so one to eight pairs give cards of 8 MB to 64 MB. The three top address bits pick a pair, and the address bits below them, except bit 0, go to every device.

The card bus has no back-pressure: the block never inserts wait states. Every access path is combinational. Only the card-ready output is registered, on `clk`.

Top module: `pccard_flash_decode`

## Requirements
- R1: When `ce_lo_n` and `ce_hi_n` are both low, the low device is read on `host_rdata[7:0]` and the high device on `host_rdata[15:8]`. A write sends `host_wdata[7:0]` to the low device and `host_wdata[15:8]` to the high device. `addr[0]` has no effect on this.
- R2: When only `ce_lo_n` is low, `addr[0]`=0 accesses the low device and `addr[0]`=1 accesses the high device. In both cases the data moves on `host_rdata[7:0]` / `host_wdata[7:0]`, and `host_rdata[15:8]` reads 8'hFF.
- R3: When only `ce_hi_n` is low, the high device is accessed on lane [15:8], and `host_rdata[7:0]` reads 8'hFF. Any host lane whose enable is high reads 8'hFF.
- R4: `addr[25:23]` is the pair index. It drives `pair_cs_n[index]` low, and at most one pair select is low at a time. `dev_addr` equals `addr[22:1]`. An index at or above `PAIRS` selects no pair and reads 16'hFFFF.
- R5: With `reg_n` low and a lane enabled, `attr_sel_n` goes low and no pair select or strobe is active. The low lane returns `attr_rdata` and the high lane returns 8'hFF.
- R6: With `wp` high, `wr_lo_n` and `wr_hi_n` stay high. Read strobes and read data are unchanged.
- R7: `card_ready` is the AND of all `dev_ready` bits as sampled at the previous `clk` edge. It is 0 while `rst` is high.
- R8: While `rst` is high, every pair select, every strobe and `attr_sel_n` are inactive (high), and `host_rdata_en` is 0.
- R9: `wait_n`, `bvd1` and `bvd2` are 1 at all times.
- R10: `host_rdata_en` is 1 exactly when `oe_n` is low, `we_n` is high, at least one lane enable is low and `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the ready register |
| rst | input | 1 | Card reset, active high |
| addr | input | 26 | Host byte address |
| ce_lo_n | input | 1 | Even-byte (low lane) enable, active low |
| ce_hi_n | input | 1 | Odd-byte (high lane) enable, active low |
| oe_n | input | 1 | Host read strobe, active low |
| we_n | input | 1 | Host write strobe, active low |
| reg_n | input | 1 | Attribute plane select, active low |
| wp | input | 1 | Write-protect switch, high = protected |
| host_wdata | input | 16 | Write data from host |
| host_rdata | output | 16 | Read data to host |
| host_rdata_en | output | 1 | Enable of the host-side data drivers |
| pair_cs_n | output | PAIRS | Chip select per device pair, active low |
| dev_addr | output | 22 | In-device address to all devices |
| rd_lo_n | output | 1 | Read strobe, low-byte devices |
| rd_hi_n | output | 1 | Read strobe, high-byte devices |
| wr_lo_n | output | 1 | Write strobe, low-byte devices |
| wr_hi_n | output | 1 | Write strobe, high-byte devices |
| arr_lo_wdata | output | 8 | Write data bus, low-byte devices |
| arr_hi_wdata | output | 8 | Write data bus, high-byte devices |
| arr_lo_rdata | input | 8 | Read data bus, low-byte devices |
| arr_hi_rdata | input | 8 | Read data bus, high-byte devices |
| attr_sel_n | output | 1 | Attribute memory select, active low |
| attr_rdata | input | 8 | Attribute memory read byte |
| dev_ready | input | 2*PAIRS | Ready line per device, 1 = ready |
| card_ready | output | 1 | Merged card ready |
| wait_n | output | 1 | Wait request, held high |
| bvd1 | output | 1 | Status line, held high |
| bvd2 | output | 1 | Status line, held high |

## Verification
The assertions assume that `oe_n` and `we_n` are never low together. They also assume that the host inputs are stable when `clk` rises, so the combinational selects and strobes settle before they are sampled. The bench changes inputs only at the falling edge and never drives both strobes low together. It sweeps every pair index, including the ones beyond the populated count, several word addresses, all four lane-enable patterns, both planes and both protect settings. It checks all of these against a model of byte memories held in the bench.

// File: rtl/pccard_flash_pkg.sv
package pccard_flash_pkg;
  // Lane and device selection derived from the byte enables and addr[0]
  typedef struct packed {
    logic lo_lane;  // host lane [7:0] in use
    logic hi_lane;  // host lane [15:8] in use
    logic lo_dev;   // even-byte device addressed
    logic hi_dev;   // odd-byte device addressed
    logic swap;     // odd byte carried on the low lane
  } lane_sel_t;
endpackage

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer
  import pccard_flash_pkg::*;
(
  input  logic      ce_lo_n,
  input  logic      ce_hi_n,
  input  logic      a0,
  output lane_sel_t sel
);
  logic lo_only;

  always_comb begin
    lo_only     = !ce_lo_n && ce_hi_n;
    sel.lo_lane = !ce_lo_n;
    sel.hi_lane = !ce_hi_n;
    sel.swap    = lo_only && a0;
    sel.lo_dev  = !ce_lo_n && !(lo_only && a0);
    sel.hi_dev  = !ce_hi_n || (lo_only && a0);
  end
endmodule

// File: rtl/pccard_pair_decode.sv
module pccard_pair_decode #(
  parameter int PAIRS = 8,
  parameter int SEL_W = 3
) (
  input  logic             en,
  input  logic [SEL_W-1:0] idx,
  output logic [PAIRS-1:0] cs_n,
  output logic             in_range
);
  localparam logic [SEL_W:0] LIMIT = (SEL_W + 1)'(PAIRS);

  assign in_range = ({1'b0, idx} < LIMIT);

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign cs_n[i] = !(en && (idx == SEL_W'(i)));
  end
endmodule

// File: rtl/pccard_ready_agg.sv
module pccard_ready_agg #(
  parameter int NDEV = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDEV-1:0] dev_ready,
  output logic            card_ready
);
  always_ff @(posedge clk) begin
    if (rst) card_ready <= 1'b0;
    else     card_ready <= &dev_ready;
  end

  // R7: merged ready follows the AND of the device lines one edge later
  a_r7_ready_merge: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (card_ready == $past(&dev_ready)));
endmodule

// File: rtl/pccard_flash_decode.sv
module pccard_flash_decode
  import pccard_flash_pkg::*;
#(
  parameter int PAIRS  = 8,
  parameter int DEV_AW = 22,
  parameter int SEL_W  = 3,
  localparam int ADDR_W = 1 + DEV_AW + SEL_W,
  localparam int NDEV   = 2 * PAIRS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_lo_n,
  input  logic              ce_hi_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              reg_n,
  input  logic              wp,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              host_rdata_en,
  output logic [PAIRS-1:0]  pair_cs_n,
  output logic [DEV_AW-1:0] dev_addr,
  output logic              rd_lo_n,
  output logic              rd_hi_n,
  output logic              wr_lo_n,
  output logic              wr_hi_n,
  output logic [7:0]        arr_lo_wdata,
  output logic [7:0]        arr_hi_wdata,
  input  logic [7:0]        arr_lo_rdata,
  input  logic [7:0]        arr_hi_rdata,
  output logic              attr_sel_n,
  input  logic [7:0]        attr_rdata,
  input  logic [NDEV-1:0]   dev_ready,
  output logic              card_ready,
  output logic              wait_n,
  output logic              bvd1,
  output logic              bvd2
);
  lane_sel_t  ls;
  logic       any_lane;
  logic       flash_go;
  logic       in_range;
  logic       flash_acc;
  logic [7:0] lo_byte;
  logic [7:0] hi_byte;

  pccard_lane_steer u_steer (
    .ce_lo_n (ce_lo_n),
    .ce_hi_n (ce_hi_n),
    .a0      (addr[0]),
    .sel     (ls)
  );

  assign any_lane  = ls.lo_lane || ls.hi_lane;
  assign flash_go  = any_lane && reg_n && !rst;
  assign flash_acc = flash_go && in_range;

  pccard_pair_decode #(.PAIRS(PAIRS), .SEL_W(SEL_W)) u_pairs (
    .en       (flash_go),
    .idx      (addr[ADDR_W-1 -: SEL_W]),
    .cs_n     (pair_cs_n),
    .in_range (in_range)
  );

  assign dev_addr = addr[DEV_AW:1];

  // Device strobes
  assign rd_lo_n = !(flash_acc && !oe_n && ls.lo_dev);
  assign rd_hi_n = !(flash_acc && !oe_n && ls.hi_dev);
  assign wr_lo_n = !(flash_acc && !we_n && !wp && ls.lo_dev);
  assign wr_hi_n = !(flash_acc && !we_n && !wp && ls.hi_dev);

  // Write steering: an odd byte from an 8-bit host rides the low lane
  assign arr_lo_wdata = host_wdata[7:0];
  assign arr_hi_wdata = ls.swap ? host_wdata[7:0] : host_wdata[15:8];

  assign attr_sel_n = !(any_lane && !reg_n && !rst);

  // Read steering
  always_comb begin
    lo_byte = 8'hFF;
    hi_byte = 8'hFF;
    if (!reg_n) begin
      if (ls.lo_lane) lo_byte = attr_rdata;
    end else if (in_range) begin
      if (ls.lo_lane) lo_byte = ls.swap ? arr_hi_rdata : arr_lo_rdata;
      if (ls.hi_lane) hi_byte = arr_hi_rdata;
    end
  end

  assign host_rdata    = {hi_byte, lo_byte};
  assign host_rdata_en = !rst && !oe_n && we_n && any_lane;

  assign wait_n = 1'b1;
  assign bvd1   = 1'b1;
  assign bvd2   = 1'b1;

  pccard_ready_agg #(.NDEV(NDEV)) u_ready (
    .clk        (clk),
    .rst        (rst),
    .dev_ready  (dev_ready),
    .card_ready (card_ready)
  );

  // R4: never more than one pair selected
  a_r4_one_pair: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~pair_cs_n));
  // R5: attribute plane access keeps the flash array idle
  a_r5_attr_no_flash: assert property (@(posedge clk) disable iff (rst)
    !reg_n |-> (&pair_cs_n && rd_lo_n && rd_hi_n && wr_lo_n && wr_hi_n));
  // R6: write protect blocks every write strobe
  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (rst)
    wp |-> (wr_lo_n && wr_hi_n));
  // R8: reset parks every select
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |-> (&pair_cs_n && attr_sel_n && !host_rdata_en));
  // R10: host drivers only during a read
  a_r10_drive_read: assert property (@(posedge clk) disable iff (rst)
    host_rdata_en |-> (!oe_n && we_n));
  // R4: a strobe implies some pair is selected
  a_r4_strobe_has_cs: assert property (@(posedge clk) disable iff (rst)
    !(rd_lo_n && rd_hi_n && wr_lo_n && wr_hi_n) |-> !(&pair_cs_n));
endmodule

// File: tb/pccard_flash_decode_bench.sv
module pccard_flash_decode_bench;
  localparam int PAIRS = 3;
  localparam int NDEV  = 2 * PAIRS;

  logic        clk = 1'b0;
  logic        rst;
  logic [25:0] addr;
  logic        ce_lo_n, ce_hi_n, oe_n, we_n, reg_n, wp;
  logic [15:0] host_wdata, host_rdata;
  logic        host_rdata_en;
  logic [PAIRS-1:0] pair_cs_n;
  logic [21:0] dev_addr;
  logic        rd_lo_n, rd_hi_n, wr_lo_n, wr_hi_n;
  logic [7:0]  arr_lo_wdata, arr_hi_wdata, arr_lo_rdata, arr_hi_rdata;
  logic        attr_sel_n;
  logic [7:0]  attr_rdata;
  logic [NDEV-1:0] dev_ready;
  logic        card_ready, wait_n, bvd1, bvd2;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  pccard_flash_decode #(.PAIRS(PAIRS)) u_pccard_flash_decode (
    .clk(clk), .rst(rst), .addr(addr), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n),
    .oe_n(oe_n), .we_n(we_n), .reg_n(reg_n), .wp(wp),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdata_en(host_rdata_en), .pair_cs_n(pair_cs_n),
    .dev_addr(dev_addr), .rd_lo_n(rd_lo_n), .rd_hi_n(rd_hi_n),
    .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .arr_lo_wdata(arr_lo_wdata),
    .arr_hi_wdata(arr_hi_wdata), .arr_lo_rdata(arr_lo_rdata),
    .arr_hi_rdata(arr_hi_rdata), .attr_sel_n(attr_sel_n),
    .attr_rdata(attr_rdata), .dev_ready(dev_ready), .card_ready(card_ready),
    .wait_n(wait_n), .bvd1(bvd1), .bvd2(bvd2)
  );

  // Byte memories standing in for the devices
  function automatic logic [7:0] mem_lo(int p, int w);
    return 8'((p * 37 + w * 11 + 3) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] mem_hi(int p, int w);
    return 8'((p * 53 + w * 7 + 9) ^ 8'hC3);
  endfunction

  always_comb begin
    arr_lo_rdata = 8'h00;
    arr_hi_rdata = 8'h00;
    for (int p = 0; p < PAIRS; p++) begin
      if (!pair_cs_n[p] && !rd_lo_n) arr_lo_rdata = mem_lo(p, int'(dev_addr[2:0]));
      if (!pair_cs_n[p] && !rd_hi_n) arr_hi_rdata = mem_hi(p, int'(dev_addr[2:0]));
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode: 0 word, 1 low only a0=0, 2 low only a0=1, 3 high only
  task automatic set_bus(int p, int w, int mode);
    addr = 26'((p << 23) | (w << 1));
    addr[0]  = (mode == 2) || (mode == 3 && w[0]);
    ce_lo_n  = (mode == 3);
    ce_hi_n  = (mode == 1 || mode == 2);
  endtask

  task automatic idle_bus();
    ce_lo_n = 1'b1; ce_hi_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; reg_n = 1'b1;
  endtask

  initial begin
    rst = 1'b1; wp = 1'b0; addr = '0; host_wdata = '0;
    attr_rdata = 8'hA5; dev_ready = '1;
    idle_bus();
    ce_lo_n = 1'b0; ce_hi_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 cs in reset", 32'(pair_cs_n), 32'((1 << PAIRS) - 1));
    check("R8 attr_sel in reset", 32'(attr_sel_n), 1);
    check("R8 drive in reset", 32'(host_rdata_en), 0);
    check("R7 ready low in reset", 32'(card_ready), 0);
    check("R9 static lines", {29'd0, wait_n, bvd1, bvd2}, 32'd7);
    @(negedge clk);
    rst = 1'b0;
    idle_bus();

    // Reads, flash plane
    for (int p = 0; p < 8; p++)
      for (int w = 0; w < 4; w++)
        for (int m = 0; m < 4; m++) begin
          logic [7:0] lo, hi, elo, ehi;
          @(negedge clk);
          set_bus(p, w, m); oe_n = 1'b0; we_n = 1'b1; reg_n = 1'b1;
          wp = w[1];
          #1;
          lo = mem_lo(p, w); hi = mem_hi(p, w);
          case (m)
            0: begin elo = lo;    ehi = hi;    end
            1: begin elo = lo;    ehi = 8'hFF; end
            2: begin elo = hi;    ehi = 8'hFF; end
            default: begin elo = 8'hFF; ehi = hi; end
          endcase
          if (p >= PAIRS) begin elo = 8'hFF; ehi = 8'hFF; end
          check(m == 0 ? "R1 word read" : (m == 3 ? "R3 high-only read" : "R2 byte read"),
                32'(host_rdata), 32'({ehi, elo}));
          check("R4 pair select", 32'(pair_cs_n),
                p < PAIRS ? 32'(~(3'b1 << p) & 3'b111) : 32'd7);
          check("R4 device address", 32'(dev_addr), 32'(w));
          check("R10 drive on read", 32'(host_rdata_en), 1);
          check("R6 no write strobe on read", {30'd0, wr_lo_n, wr_hi_n}, 32'd3);
        end

    // Writes with and without protect
    for (int p = 0; p < 8; p++)
      for (int w = 0; w < 4; w++)
        for (int m = 0; m < 4; m++)
          for (int pr = 0; pr < 2; pr++) begin
            logic go, elo_s, ehi_s;
            @(negedge clk);
            set_bus(p, w, m); oe_n = 1'b1; we_n = 1'b0; reg_n = 1'b1;
            wp = pr[0];
            host_wdata = 16'((p << 12) | (w << 8) | 8'h3C | m);
            #1;
            go    = (p < PAIRS) && (pr == 0);
            elo_s = go && (m == 0 || m == 1);
            ehi_s = go && (m != 1);
            check(pr ? "R6 protected write" : "R1 R2 R3 write strobes",
                  {30'd0, wr_lo_n, wr_hi_n}, {30'd0, !elo_s, !ehi_s});
            check("R10 no drive on write", 32'(host_rdata_en), 0);
            if (ehi_s)
              check(m == 2 ? "R2 odd byte on low lane" : "R1 high byte write",
                    32'(arr_hi_wdata), m == 2 ? 32'(host_wdata[7:0]) : 32'(host_wdata[15:8]));
            if (elo_s)
              check("R1 low byte write", 32'(arr_lo_wdata), 32'(host_wdata[7:0]));
          end

    // Attribute plane
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      set_bus(1, 2, m); oe_n = 1'b0; we_n = 1'b1; reg_n = 1'b0; wp = 1'b0;
      #1;
      check("R5 attr read data", 32'(host_rdata),
            (m == 3) ? 32'hFFFF : 32'({8'hFF, attr_rdata}));
      check("R5 attr select", 32'(attr_sel_n), 0);
      check("R5 no pair select", 32'(pair_cs_n), 32'd7);
      @(negedge clk);
      oe_n = 1'b1; we_n = 1'b0;
      #1;
      check("R5 attr write blocks flash", {30'd0, wr_lo_n, wr_hi_n}, 32'd3);
    end

    // Idle: no lane enabled
    @(negedge clk);
    idle_bus(); oe_n = 1'b0;
    #1;
    check("R10 no drive without lane", 32'(host_rdata_en), 0);
    check("R4 no select without lane", 32'(pair_cs_n), 32'd7);

    // Ready aggregation
    @(negedge clk); dev_ready = '1;
    @(posedge clk); #1;
    check("R7 all ready", 32'(card_ready), 1);
    for (int d = 0; d < NDEV; d++) begin
      @(negedge clk); dev_ready = '1; dev_ready[d] = 1'b0;
      #1;
      check("R7 registered, not yet low", 32'(card_ready), 1);
      @(posedge clk); #1;
      check("R7 one busy device", 32'(card_ready), 0);
      @(negedge clk); dev_ready = '1;
      @(posedge clk); #1;
      check("R7 ready again", 32'(card_ready), 1);
    end

    // Reset mid-access
    @(negedge clk);
    set_bus(0, 1, 0); oe_n = 1'b0; we_n = 1'b1; reg_n = 1'b1; rst = 1'b1;
    #1;
    check("R8 reset forces cs high", 32'(pair_cs_n), 32'd7);
    check("R8 reset strobes", {28'd0, rd_lo_n, rd_hi_n, wr_lo_n, wr_hi_n}, 32'hF);
    @(posedge clk); #1;
    check("R7 reset clears ready", 32'(card_ready), 0);
    check("R9 static lines", {29'd0, wait_n, bvd1, bvd2}, 32'd7);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule